// File: doc/BRIEF.md
# Conversion Result Latch with Range Flags

This block sits between the results counter of an integrating converter and the display path. A sequencer supplies the current position within the conversion cycle. During a fixed window at the end of each cycle the block drives an active-low strobe. On the clock edge where that strobe falls, the block copies the signed counter value into a display register. On the same edge it classifies the magnitude of that value against an upper and a lower count limit, which gives the overrange and underrange flags.

A two-bit mode input chooses how the display register behaves. In free-run the register updates once per cycle. In hold the register and both flags stay frozen. In live mode the register follows the counter on every clock, so the count can be watched while it runs. The flag pins model weak bidirectional pins. When an outside source drives a pin, its value replaces the internal flag on that pin, and it also lights a decimal point.

Top module: `result_latch`

## Requirements
- R1: `latch_n` is low in the clock after any cycle in which `cyc_pos` >= CYCLE_LEN-STROBE_LEN, and high in the clock after any other cycle.
- R2: In free-run mode (`hold_mode` = 2'b00), `disp_value` takes the `live_count` value sampled in the cycle whose edge brings `latch_n` from high to low. At every other edge it keeps its value.
- R3: At each capture in free-run or live mode, the overrange flag is set exactly when the absolute value of the captured count is greater than OVER_LIM (19,999 by default).
- R4: At each capture in free-run or live mode, the underrange flag is set exactly when the absolute value is less than UNDER_LIM (1,000 by default). The two flags are never set together. The most negative count is treated as a large magnitude.
- R5: Between captures, both flags keep their values.
- R6: In hold mode (`hold_mode` = 2'b01), `disp_value` and both flags do not change, even across the strobe window. The strobe itself keeps running.
- R7: In live mode (`hold_mode` = 2'b10), `disp_value` equals the `live_count` of the previous clock, and `disp_src_live` is high one clock after live mode is selected. The flags still update at each capture.
- R8: A change from live mode to hold mode freezes the value last shown, which is the final live sample.
- R9: When `or_ext_en` (or `ur_ext_en`) is high, `or_pin` (or `ur_pin`) equals the external value, and `dp_msd_on` (or `dp_second_on`) equals that value too. When the enable is low, the pin shows the internal flag and the decimal point output is 0.
- R10: A synchronous active-low reset sets `disp_value` to 0, clears both flags and `disp_src_live`, and drives `latch_n` high.
- R11: The code 2'b11 on `hold_mode` behaves as free-run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_pos | input | POS_W | Position within the conversion cycle, 0..CYCLE_LEN-1 |
| live_count | input | RES_W | Running results counter, two's complement |
| hold_mode | input | 2 | 00 free-run, 01 hold, 10 live, 11 free-run |
| or_ext_en | input | 1 | An outside source drives the overrange pin |
| or_ext_val | input | 1 | Level driven by that source |
| ur_ext_en | input | 1 | An outside source drives the underrange pin |
| ur_ext_val | input | 1 | Level driven by that source |
| disp_value | output | RES_W | Value sent to the display, two's complement |
| disp_src_live | output | 1 | High while the display follows the live counter |
| latch_n | output | 1 | Active-low end-of-cycle strobe |
| or_pin | output | 1 | Overrange pin level |
| ur_pin | output | 1 | Underrange pin level |
| dp_msd_on | output | 1 | Most significant decimal point lit from the overrange pin |
| dp_second_on | output | 1 | Second decimal point lit from the underrange pin |

## Verification
The assertions assume that `cyc_pos` advances by one per clock and wraps from CYCLE_LEN-1 to 0. Under that assumption the strobe falls exactly once per cycle. They also assume that `hold_mode` and the override inputs change only between clock edges. The stimulus comes from a counter that wraps at the cycle length, and all inputs are applied one nanosecond after the rising edge. Inside each cycle the live count is built so that it equals a chosen test value exactly at the first window position and differs from it at every other position. A capture one clock early or late therefore shows up as a wrong value.

// File: rtl/res_latch_pkg.sv
`timescale 1ns/1ps
// Shared types for the result latch.
// Assumes: nothing beyond IEEE 1800-2017.
package res_latch_pkg;
    typedef enum logic [1:0] {
        HM_FREE = 2'b00,
        HM_HOLD = 2'b01,
        HM_LIVE = 2'b10,
        HM_RSVD = 2'b11
    } hold_mode_e;
endpackage

// File: rtl/strobe_gen.sv
`timescale 1ns/1ps
// Drives the active-low end-of-cycle strobe from the cycle position.
// It also gives a one-clock capture pulse in the cycle whose edge makes
// the strobe fall.
// Assumes: cyc_pos counts 0..CYCLE_LEN-1 by one per clock and wraps.
module strobe_gen #(
    parameter int CYCLE_LEN  = 30000,
    parameter int STROBE_LEN = 100,
    parameter int POS_W      = $clog2(CYCLE_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] cyc_pos,
    output logic             latch_n,
    output logic             cap_pulse
);
    localparam logic [POS_W-1:0] WIN_START = POS_W'(CYCLE_LEN - STROBE_LEN);

    logic in_win;
    logic latch_n_q;

    // Window decode: the final STROBE_LEN positions of the cycle.
    always_comb in_win = (cyc_pos >= WIN_START);

    // Capture fires when the window opens while the strobe is still high.
    always_comb cap_pulse = in_win & latch_n_q;

    // Strobe register: low for the window, high at any other time.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_n_q <= 1'b1;
        else        latch_n_q <= ~in_win;
    end

    assign latch_n = latch_n_q;

    // R1: the strobe follows the window one clock later.
    p_strobe_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_pos >= WIN_START) |=> !latch_n);
    p_strobe_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_pos < WIN_START) |=> latch_n);
endmodule

// File: rtl/range_classify.sv
`timescale 1ns/1ps
// Compares the magnitude of a signed count with the upper and lower limits.
// Assumes: UNDER_LIM <= OVER_LIM. The most negative code maps to a
// positive magnitude, because the magnitude path is one bit wider.
module range_classify #(
    parameter int RES_W     = 18,
    parameter int OVER_LIM  = 19999,
    parameter int UNDER_LIM = 1000
) (
    input  logic [RES_W-1:0] value,
    output logic             is_over,
    output logic             is_under
);
    localparam int MAG_W = RES_W + 1;
    localparam logic [MAG_W-1:0] OVER_M  = MAG_W'(OVER_LIM);
    localparam logic [MAG_W-1:0] UNDER_M = MAG_W'(UNDER_LIM);

    logic [MAG_W-1:0] ext;
    logic [MAG_W-1:0] mag;

    // Sign-extend by one bit, then take the absolute value.
    always_comb begin
        ext = {value[RES_W-1], value};
        mag = value[RES_W-1] ? (~ext + 1'b1) : ext;
    end

    // Limit compares.
    always_comb begin
        is_over  = (mag > OVER_M);
        is_under = (mag < UNDER_M);
    end
endmodule

// File: rtl/result_hold.sv
`timescale 1ns/1ps
// Holds the display register, the range flags and the source select.
// The mode decides whether the register freezes, updates at capture, or
// follows the counter.
// Assumes: cap arrives as a single-clock pulse once per cycle.
module result_hold
    import res_latch_pkg::*;
#(
    parameter int RES_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [RES_W-1:0] live,
    input  logic             cap,
    input  logic             is_over,
    input  logic             is_under,
    output logic [RES_W-1:0] disp_q,
    output logic             of_q,
    output logic             uf_q,
    output logic             src_q
);
    logic is_hold;
    logic is_live;

    // Mode decode. The reserved code falls through to free-run.
    always_comb begin
        is_hold = (mode == HM_HOLD);
        is_live = (mode == HM_LIVE);
    end

    // Display register: follows in live mode, loads at capture unless held.
    always_ff @(posedge clk) begin
        if (!rst_n)                  disp_q <= '0;
        else if (is_live)            disp_q <= live;
        else if (!is_hold && cap)    disp_q <= live;
    end

    // Range flags: classified at capture, frozen in hold mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            of_q <= 1'b0;
            uf_q <= 1'b0;
        end else if (!is_hold && cap) begin
            of_q <= is_over;
            uf_q <= is_under;
        end
    end

    // Source select register: high while the display follows the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= is_live;
    end

    // R6: nothing moves in hold mode.
    p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_hold |=> ($stable(disp_q) && $stable(of_q) && $stable(uf_q)));
    // R7: live mode shows the previous counter sample.
    p_live_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_live |=> (disp_q == $past(live)));
    // R5: flags stay put when there is no capture.
    p_flags_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> ($stable(of_q) && $stable(uf_q)));
    // R4: the two flags are never set together.
    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(of_q && uf_q));
endmodule

// File: rtl/flag_pin.sv
`timescale 1ns/1ps
// Models one weak bidirectional flag pin. An outside driver takes priority
// over the internal flag, and its level also lights a decimal point.
// Assumes: the outside driver is strong enough to win over the weak output.
module flag_pin (
    input  logic flag,
    input  logic ext_en,
    input  logic ext_val,
    output logic pin,
    output logic dp_on
);
    // Pin level and decimal point request.
    always_comb begin
        pin   = ext_en ? ext_val : flag;
        dp_on = ext_en & ext_val;
    end
endmodule

// File: rtl/result_latch.sv
`timescale 1ns/1ps
// Top of the conversion result latch: strobe timing, range classification,
// hold-mode register and pin overrides.
// Assumes: cyc_pos comes from a free-running sequencer, and live_count is
// two's complement.
module result_latch
    import res_latch_pkg::*;
#(
    parameter int CYCLE_LEN  = 30000,
    parameter int STROBE_LEN = 100,
    parameter int RES_W      = 18,
    parameter int OVER_LIM   = 19999,
    parameter int UNDER_LIM  = 1000,
    parameter int POS_W      = $clog2(CYCLE_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] cyc_pos,
    input  logic [RES_W-1:0] live_count,
    input  logic [1:0]       hold_mode,
    input  logic             or_ext_en,
    input  logic             or_ext_val,
    input  logic             ur_ext_en,
    input  logic             ur_ext_val,
    output logic [RES_W-1:0] disp_value,
    output logic             disp_src_live,
    output logic             latch_n,
    output logic             or_pin,
    output logic             ur_pin,
    output logic             dp_msd_on,
    output logic             dp_second_on
);
    localparam int NPIN = 2;

    logic cap;
    logic is_over;
    logic is_under;
    logic of_q;
    logic uf_q;
    logic [NPIN-1:0] flags;
    logic [NPIN-1:0] ext_en;
    logic [NPIN-1:0] ext_val;
    logic [NPIN-1:0] pins;
    logic [NPIN-1:0] dps;

    strobe_gen #(
        .CYCLE_LEN (CYCLE_LEN),
        .STROBE_LEN(STROBE_LEN),
        .POS_W     (POS_W)
    ) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_pos  (cyc_pos),
        .latch_n  (latch_n),
        .cap_pulse(cap)
    );

    range_classify #(
        .RES_W    (RES_W),
        .OVER_LIM (OVER_LIM),
        .UNDER_LIM(UNDER_LIM)
    ) u_class (
        .value   (live_count),
        .is_over (is_over),
        .is_under(is_under)
    );

    result_hold #(
        .RES_W(RES_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (hold_mode),
        .live    (live_count),
        .cap     (cap),
        .is_over (is_over),
        .is_under(is_under),
        .disp_q  (disp_value),
        .of_q    (of_q),
        .uf_q    (uf_q),
        .src_q   (disp_src_live)
    );

    // Gather both pins into vectors: index 0 overrange, index 1 underrange.
    always_comb begin
        flags   = {uf_q, of_q};
        ext_en  = {ur_ext_en, or_ext_en};
        ext_val = {ur_ext_val, or_ext_val};
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        flag_pin u_pin (
            .flag   (flags[i]),
            .ext_en (ext_en[i]),
            .ext_val(ext_val[i]),
            .pin    (pins[i]),
            .dp_on  (dps[i])
        );
    end

    assign or_pin       = pins[0];
    assign ur_pin       = pins[1];
    assign dp_msd_on    = dps[0];
    assign dp_second_on = dps[1];
endmodule

// File: tb/result_latch_bench.sv
`timescale 1ns/1ps
module result_latch_bench;
    localparam int CYC   = 64;
    localparam int STB   = 8;
    localparam int START = CYC - STB;
    localparam int POS_W = 6;
    localparam int RW    = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [POS_W-1:0] cyc_pos = '0;
    logic [RW-1:0] live_count = '0;
    logic [1:0] hold_mode = 2'b00;
    logic or_ext_en = 1'b0, or_ext_val = 1'b0, ur_ext_en = 1'b0, ur_ext_val = 1'b0;
    logic [RW-1:0] disp_value;
    logic disp_src_live, latch_n, or_pin, ur_pin, dp_msd_on, dp_second_on;

    int n_cmp = 0;
    int n_bad = 0;
    bit run = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    result_latch #(.CYCLE_LEN(CYC), .STROBE_LEN(STB), .POS_W(POS_W)) u_result_latch (
        .clk(clk), .rst_n(rst_n), .cyc_pos(cyc_pos), .live_count(live_count),
        .hold_mode(hold_mode), .or_ext_en(or_ext_en), .or_ext_val(or_ext_val),
        .ur_ext_en(ur_ext_en), .ur_ext_val(ur_ext_val), .disp_value(disp_value),
        .disp_src_live(disp_src_live), .latch_n(latch_n), .or_pin(or_pin),
        .ur_pin(ur_pin), .dp_msd_on(dp_msd_on), .dp_second_on(dp_second_on));

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, written from the requirements.
    int m_disp = 0;
    bit m_of = 0, m_uf = 0, m_latch_n = 1, m_src = 0, m_cap = 0;
    string m_dtag = "R2";

    always @(posedge clk) begin
        int v, mag;
        bit win;
        if (!rst_n) begin
            m_disp = 0; m_of = 0; m_uf = 0; m_latch_n = 1; m_src = 0; m_cap = 0;
        end else begin
            v   = int'($signed(live_count));
            mag = (v < 0) ? -v : v;
            win = (int'(cyc_pos) >= START);
            m_cap = win && m_latch_n;
            m_latch_n = !win;
            case (hold_mode)
                2'b01: m_dtag = "R6";
                2'b10: m_dtag = "R7";
                2'b11: m_dtag = "R11";
                default: m_dtag = "R2";
            endcase
            if (hold_mode == 2'b10) m_disp = v;
            else if (hold_mode != 2'b01 && m_cap) m_disp = v;
            if (hold_mode != 2'b01 && m_cap) begin
                m_of = (mag > 19999);
                m_uf = (mag < 1000);
            end
            m_src = (hold_mode == 2'b10);
        end
    end

    // Compare on every falling edge once reset is released.
    always @(negedge clk) begin
        if (run && !done) begin
            check("R1", int'(latch_n), int'(m_latch_n));
            check(m_dtag, int'($signed(disp_value)), m_disp);
            check("R7", int'(disp_src_live), int'(m_src));
            check(or_ext_en ? "R9" : (m_cap ? "R3" : "R5"), int'(or_pin),
                  or_ext_en ? int'(or_ext_val) : int'(m_of));
            check(ur_ext_en ? "R9" : (m_cap ? "R4" : "R5"), int'(ur_pin),
                  ur_ext_en ? int'(ur_ext_val) : int'(m_uf));
            check("R9", int'(dp_msd_on), int'(or_ext_en & or_ext_val));
            check("R9", int'(dp_second_on), int'(ur_ext_en & ur_ext_val));
        end
    end

    initial begin
        int bases[15] = '{0, 999, 1000, 19999, 20000, -20000, -19999, -1000, -999,
                          -131072, 5000, 12345, 700, 30000, 1500};
        logic [1:0] modes[15] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
                                  2'b00, 2'b00, 2'b00, 2'b01, 2'b11, 2'b10, 2'b01, 2'b00};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check("R10", int'(disp_value), 0);
        check("R10", int'(latch_n), 1);
        check("R10", int'(or_pin) + int'(ur_pin), 0);
        check("R10", int'(disp_src_live), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        run = 1'b1;
        for (int c = 0; c < 15; c++) begin
            for (int k = 0; k < CYC; k++) begin
                cyc_pos    = POS_W'(k);
                live_count = RW'(bases[c] + k - START);
                hold_mode  = modes[c];
                or_ext_en  = (c % 2 == 1) && k[2];
                or_ext_val = k[3];
                ur_ext_en  = (c % 2 == 1) && k[1];
                ur_ext_val = k[0];
                if (c == 13 && k == 10) begin
                    // R8: live to hold keeps the last live sample on display
                    check("R8", int'($signed(disp_value)), 700 + (CYC - 1 - START));
                end
                @(posedge clk); #1;
            end
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule